// File: doc/BRIEF.md
# Pipeline Exception Flush Controller

This block sits beside a five-stage in-order integer pipeline (fetch, decode, execute, memory, writeback) and decides when the pipeline must be taken over by a trap. Faults come from the execute and memory stages, and a level-sensitive external interrupt arrives from outside the clock domain. When one is accepted, the controller selects the instruction that faults. In the same cycle it raises a flush for that instruction's stage and for every younger stage. Each flushed latch is then loaded with zeros, which decodes as a no-op with all write enables off. Older instructions keep flowing to writeback, and a trap is pushed into the next fetch.

Alongside the flush, the controller stores what is needed to restart. Branches with two delay slots make a single saved PC insufficient. The block therefore keeps a short chain: the faulting PC, followed by the PCs of up to two younger in-flight instructions that sit in delay slots. The chain, a cause code and a one-cycle handler-entry strobe are visible the cycle after the trap. The controller also gates the execute stage's condition-code write, so that a squashed instruction cannot disturb a branch that will be re-executed.

Top module: `exc_flush_ctrl`

## Requirements
- R1: When the memory-stage instruction is valid and faults, it is selected even if the execute stage faults in the same cycle. All four stages are flushed (`flush` = 4'b1111), and the next `cause` is `mem_code`.
- R2: When only the valid execute-stage instruction faults, `flush` = 4'b0111: fetch, decode and execute are cleared, and memory is left to retire. `epc0` then becomes `ex_pc`. Bit 0 of `flush` is fetch, bit 1 decode, bit 2 execute and bit 3 memory.
- R3: `trap_inject` is high in exactly the cycles in which any `flush` bit is high. The flush is combinational, so it acts in the same cycle as the request.
- R4: One clock edge after `trap_inject`, `handler_go` is high for one cycle and `epc_vld[0]` is 1. `epc0` and `cause` hold the faulting PC and its code until the next trap.
- R5: Delay-slot chain. `epc1`/`epc_vld[1]` take the PC of the stage just younger than the faulting one, but only if that stage is valid and its `stg_slot` bit is set. `epc2`/`epc_vld[2]` do the same for the next younger stage, and only when entry 1 is valid. Invalid entries read as zero.
- R6: `ext_irq` passes through a two-flop synchronizer. It is taken only when `irq_en` is 1, no synchronous fault is present, and at least one stage is valid. The interrupt is attached to the oldest valid stage among memory, execute, decode and fetch. That stage and all younger ones are flushed, and the next `cause` is `IRQ_CAUSE` (default 4'hF).
- R7: With `irq_en` = 0, the interrupt is ignored: there is no flush, no `handler_go`, and the saved PC and cause are unchanged.
- R8: `cc_we` equals `ex_cc_we` when the execute stage is valid and not flushed, and is 0 otherwise.
- R9: Fault flags of invalid stages are ignored: they produce no flush and no trap.
- R10: After reset, all flushes, `trap_inject`, `handler_go`, `epc_vld`, the saved PCs and `cause` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stg_vld | input | 4 | Per-stage valid, bit 0 fetch to bit 3 memory |
| stg_slot | input | 4 | Per-stage flag: the instruction occupies a branch delay slot |
| if_pc | input | PCW | PC in fetch |
| id_pc | input | PCW | PC in decode |
| ex_pc | input | PCW | PC in execute |
| mem_pc | input | PCW | PC in memory |
| ex_fault | input | 1 | Execute-stage fault request |
| ex_code | input | CW | Execute-stage fault cause |
| mem_fault | input | 1 | Memory-stage fault request |
| mem_code | input | CW | Memory-stage fault cause |
| ext_irq | input | 1 | Asynchronous external interrupt, level |
| irq_en | input | 1 | Maskable interrupt enable |
| ex_cc_we | input | 1 | Condition-code write request from execute |
| flush | output | 4 | Zero-load command per stage latch |
| trap_inject | output | 1 | Force trap into the next fetch |
| cc_we | output | 1 | Gated condition-code write enable |
| epc0 | output | PCW | Saved faulting PC |
| epc1 | output | PCW | Saved first delay-slot PC |
| epc2 | output | PCW | Saved second delay-slot PC |
| epc_vld | output | 3 | Valid bits of the saved PC chain |
| cause | output | CW | Saved cause code |
| handler_go | output | 1 | One-cycle handler-entry strobe |

## Verification
The bench sweeps every combination of stage valids, both fault flags and delay-slot flags, and predicts the flush mask and restart chain arithmetically.

- **Simultaneous faults.** A design with the priority inverted would leave memory unflushed and report the execute cause.
- **Faults on invalid stages.** A design that ignored the valid bits would trap on bubbles.
- **Broken slot chains.** A slot flag in the far stage with no flag in the near one must leave entry 2 invalid. A design that checked each stage on its own would save an extra PC, and a restart would run one instruction too many.
- **Interrupt handling.** The interrupt tests cover attachment to the oldest stage when memory or more stages are empty, masking, an empty pipeline, and a concurrent synchronous fault. A wrong oldest-stage pick would show up as a bad flush mask or saved PC, and missing masking would show up as a spurious trap.

// File: rtl/exc_flush_ctrl.sv
`timescale 1ns/1ps
module exc_flush_ctrl #(
  parameter int PCW = 32,
  parameter int CW = 4,
  parameter int SYNC = 2,
  parameter logic [CW-1:0] IRQ_CAUSE = '1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [3:0]     stg_vld,
  input  logic [3:0]     stg_slot,
  input  logic [PCW-1:0] if_pc,
  input  logic [PCW-1:0] id_pc,
  input  logic [PCW-1:0] ex_pc,
  input  logic [PCW-1:0] mem_pc,
  input  logic           ex_fault,
  input  logic [CW-1:0]  ex_code,
  input  logic           mem_fault,
  input  logic [CW-1:0]  mem_code,
  input  logic           ext_irq,
  input  logic           irq_en,
  input  logic           ex_cc_we,
  output logic [3:0]     flush,
  output logic           trap_inject,
  output logic           cc_we,
  output logic [PCW-1:0] epc0,
  output logic [PCW-1:0] epc1,
  output logic [PCW-1:0] epc2,
  output logic [2:0]     epc_vld,
  output logic [CW-1:0]  cause,
  output logic           handler_go
);

  logic [SYNC-1:0] irq_sh;
  logic            irq_s, mem_hit, ex_hit, irq_take;
  logic [3:0]      oldest, sel;
  logic [PCW-1:0]  pcs [4];
  logic [PCW-1:0]  fpc, y1pc, y2pc;
  logic            y1ok, y2ok;
  logic [CW-1:0]   code;

  always_ff @(posedge clk) begin
    if (!rst_n) irq_sh <= '0;
    else        irq_sh <= {irq_sh[SYNC-2:0], ext_irq};
  end
  assign irq_s = irq_sh[SYNC-1];

  assign mem_hit  = stg_vld[3] & mem_fault;
  assign ex_hit   = stg_vld[2] & ex_fault;
  assign irq_take = irq_s & irq_en & ~mem_hit & ~ex_hit & (|stg_vld);

  always_comb begin
    oldest = '0;
    for (int i = 0; i < 4; i++)
      if (stg_vld[i]) oldest = 4'(1 << i);
  end

  assign sel = mem_hit  ? 4'b1000 :
               ex_hit   ? 4'b0100 :
               irq_take ? oldest  : 4'b0000;

  genvar g;
  generate
    for (g = 0; g < 4; g++) begin : g_fl
      assign flush[g] = |sel[3:g];
    end
  endgenerate

  assign trap_inject = |sel;
  assign cc_we = ex_cc_we & stg_vld[2] & ~flush[2];
  assign code = mem_hit ? mem_code : ex_hit ? ex_code : IRQ_CAUSE;

  assign pcs[0] = if_pc;
  assign pcs[1] = id_pc;
  assign pcs[2] = ex_pc;
  assign pcs[3] = mem_pc;

  always_comb begin
    fpc = '0; y1pc = '0; y2pc = '0; y1ok = 1'b0; y2ok = 1'b0;
    for (int i = 0; i < 4; i++)
      if (sel[i]) fpc = pcs[i];
    for (int i = 1; i < 4; i++)
      if (sel[i] && stg_vld[i-1] && stg_slot[i-1]) begin
        y1ok = 1'b1;
        y1pc = pcs[i-1];
      end
    for (int i = 2; i < 4; i++)
      if (sel[i] && stg_vld[i-1] && stg_slot[i-1] && stg_vld[i-2] && stg_slot[i-2]) begin
        y2ok = 1'b1;
        y2pc = pcs[i-2];
      end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      epc0 <= '0; epc1 <= '0; epc2 <= '0;
      epc_vld <= '0; cause <= '0; handler_go <= 1'b0;
    end else begin
      handler_go <= trap_inject;
      if (trap_inject) begin
        epc0    <= fpc;
        epc1    <= y1pc;
        epc2    <= y2pc;
        epc_vld <= {y2ok, y1ok, 1'b1};
        cause   <= code;
      end
    end
  end

endmodule

// File: rtl/exc_flush_chk.sv
`timescale 1ns/1ps
module exc_flush_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] stg_vld,
  input logic       ex_fault,
  input logic       mem_fault,
  input logic       irq_en,
  input logic [3:0] flush,
  input logic       trap_inject,
  input logic       cc_we,
  input logic [2:0] epc_vld,
  input logic       handler_go
);
  assert_mem_wins_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (stg_vld[3] && mem_fault) |-> (flush == 4'b1111 && trap_inject));
  assert_flush_suffix_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush[3] || flush[2]) && (!flush[2] || flush[1]) && (!flush[1] || flush[0]));
  assert_trap_flush_R3: assert property (@(posedge clk) disable iff (!rst_n)
    trap_inject == (flush != 4'b0000));
  assert_handler_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    trap_inject |=> (handler_go && epc_vld[0]));
  assert_chain_order_R5: assert property (@(posedge clk) disable iff (!rst_n)
    epc_vld[2] |-> epc_vld[1]);
  assert_irq_masked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_en && !(stg_vld[3] && mem_fault) && !(stg_vld[2] && ex_fault)) |-> !trap_inject);
  assert_cc_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cc_we |-> (!flush[2] && stg_vld[2]));
  assert_invalid_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!stg_vld[3] && !stg_vld[2] && !irq_en) |-> (flush == 4'b0000));
endmodule

bind exc_flush_ctrl exc_flush_chk u_chk (
  .clk(clk), .rst_n(rst_n), .stg_vld(stg_vld), .ex_fault(ex_fault),
  .mem_fault(mem_fault), .irq_en(irq_en), .flush(flush),
  .trap_inject(trap_inject), .cc_we(cc_we), .epc_vld(epc_vld),
  .handler_go(handler_go)
);

// File: tb/sim_exc_flush_ctrl.sv
`timescale 1ns/1ps
module sim_exc_flush_ctrl;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic [3:0]  stg_vld = '0, stg_slot = '0;
  logic [31:0] if_pc = '0, id_pc = '0, ex_pc = '0, mem_pc = '0;
  logic        ex_fault = 0, mem_fault = 0, ext_irq = 0, irq_en = 0, ex_cc_we = 0;
  logic [3:0]  ex_code = 4'h3, mem_code = 4'h5;
  logic [3:0]  flush, cause;
  logic        trap_inject, cc_we, handler_go;
  logic [31:0] epc0, epc1, epc2;
  logic [2:0]  epc_vld;

  int n_chk = 0, n_bad = 0;
  logic [31:0] x0 = '0, x1 = '0, x2 = '0;
  logic [2:0]  xv = '0;
  logic [3:0]  xc = '0;

  always #2.5 clk = ~clk;

  exc_flush_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .stg_vld(stg_vld), .stg_slot(stg_slot),
    .if_pc(if_pc), .id_pc(id_pc), .ex_pc(ex_pc), .mem_pc(mem_pc),
    .ex_fault(ex_fault), .ex_code(ex_code), .mem_fault(mem_fault),
    .mem_code(mem_code), .ext_irq(ext_irq), .irq_en(irq_en),
    .ex_cc_we(ex_cc_we), .flush(flush), .trap_inject(trap_inject),
    .cc_we(cc_we), .epc0(epc0), .epc1(epc1), .epc2(epc2),
    .epc_vld(epc_vld), .cause(cause), .handler_go(handler_go));

  task automatic chk(input string r, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", r, act, exp, $time);
    end
  endtask

  task automatic chk_regs(input string r, input logic go);
    chk({r, " handler_go"}, 64'(handler_go), 64'(go));
    chk({r, " epc0"}, 64'(epc0), 64'(x0));
    chk({r, " epc1"}, 64'(epc1), 64'(x1));
    chk({r, " epc2"}, 64'(epc2), 64'(x2));
    chk({r, " epc_vld"}, 64'(epc_vld), 64'(xv));
    chk({r, " cause"}, 64'(cause), 64'(xc));
  endtask

  function automatic logic [31:0] pc_of(input int s);
    case (s)
      0: return if_pc;
      1: return id_pc;
      2: return ex_pc;
      default: return mem_pc;
    endcase
  endfunction

  // expected trap at stage st (-1 none); updates expected saved state
  task automatic expect_trap(input string r, input int st, input logic [3:0] cd);
    logic [3:0] ef;
    logic y1, y2;
    ef = (st < 0) ? 4'b0 : 4'((1 << (st + 1)) - 1);
    chk({r, " flush"}, 64'(flush), 64'(ef));
    chk({r, " trap_inject"}, 64'(trap_inject), 64'(st >= 0));
    if (st >= 0) begin
      y1 = (st >= 1) && stg_vld[st-1] && stg_slot[st-1];
      y2 = y1 && (st >= 2) && stg_vld[st-2] && stg_slot[st-2];
      x0 = pc_of(st);
      x1 = y1 ? pc_of(st-1) : 32'h0;
      x2 = y2 ? pc_of(st-2) : 32'h0;
      xv = {y2, y1, 1'b1};
      xc = cd;
    end
  endtask

  task automatic set_pcs(input int k);
    if_pc  = 32'h1000 + 32'(k) * 32;
    id_pc  = if_pc + 4;
    ex_pc  = if_pc + 8;
    mem_pc = if_pc + 12;
  endtask

  initial begin
    #(5.0 * 200000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int st;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    // R10 reset state
    chk("R10 flush", 64'(flush), 0);
    chk("R10 trap", 64'(trap_inject), 0);
    chk_regs("R10", 1'b0);

    // R1 R2 R3 R4 R5 R8 R9: sweep valids, faults, slot flags
    ex_cc_we = 1'b1;
    for (int k = 0; k < 1024; k++) begin
      @(negedge clk);
      stg_vld = 4'(k[3:0]); stg_slot = 4'(k[7:4]);
      mem_fault = k[8]; ex_fault = k[9];
      set_pcs(k);
      #1;
      st = (stg_vld[3] && mem_fault) ? 3 : (stg_vld[2] && ex_fault) ? 2 : -1;
      expect_trap("R1/R2/R9", st, (st == 3) ? mem_code : ex_code);
      chk("R8 cc_we", 64'(cc_we), 64'(stg_vld[2] && st < 2));
      @(posedge clk); #1;
      chk_regs("R4/R5", st >= 0);
    end

    // R6: interrupt to oldest valid stage, memory empty
    @(negedge clk);
    mem_fault = 0; ex_fault = 0; ex_cc_we = 0;
    stg_vld = 4'b0110; stg_slot = 4'b0010; set_pcs(2000);
    irq_en = 1; ext_irq = 1;
    #1;
    expect_trap("R6 before sync", -1, 4'hF);
    @(posedge clk); #1;
    expect_trap("R6 one flop", -1, 4'hF);
    @(posedge clk); #1;
    expect_trap("R6 attach EX", 2, 4'hF);
    @(negedge clk); ext_irq = 0;
    @(posedge clk); #1;
    chk_regs("R6 saved", 1'b1);
    repeat (2) @(posedge clk);

    // R6: only fetch valid
    @(negedge clk);
    stg_vld = 4'b0001; set_pcs(2001); ext_irq = 1;
    repeat (2) @(posedge clk); #1;
    expect_trap("R6 attach IF", 0, 4'hF);
    // R6: synchronous fault beats interrupt
    @(negedge clk);
    stg_vld = 4'b0111; stg_slot = 4'b0011; ex_fault = 1; set_pcs(2002);
    #1;
    expect_trap("R6 fault wins", 2, ex_code);
    @(posedge clk); #1;
    chk_regs("R6 fault wins", 1'b1);
    // R6: empty pipeline takes nothing
    @(negedge clk);
    ex_fault = 0; stg_vld = 4'b0000;
    #1;
    expect_trap("R6 empty", -1, 4'hF);
    @(posedge clk); #1;
    chk_regs("R6 empty", 1'b0);

    // R7: masked interrupt ignored
    @(negedge clk);
    irq_en = 0; stg_vld = 4'b1111; set_pcs(2003);
    repeat (3) begin
      @(posedge clk); #1;
      expect_trap("R7 masked", -1, 4'hF);
      chk_regs("R7 masked", 1'b0);
    end
    @(negedge clk); ext_irq = 0;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule